// File: doc/BRIEF.md
# Two-Channel Edge-Triggered Timestamp Capture

This block watches two asynchronous input pins and, when a pin shows the kind of edge selected for its channel, stores the current value of an external free-running timer in that channel's capture register and raises the channel's event flag. An interrupt request per channel is raised while its flag and its enable are both set. The timer counter lives outside the block; its value arrives as an input bus.

Software reaches the block through a simple synchronous register bus with address, write strobe, read strobe, write data, read data and a read-modify-write qualifier. One 8-bit control/status word holds the flags, the interrupt enables and the edge-mode fields for both channels. The two capture registers have read-only addresses of their own. Flags can only be cleared by software, by writing 0 to them. A read made as part of a read-modify-write access returns every flag as 1, so writing the word back never clears a flag by accident.

Top module: `cap_unit_top`

## Requirements
- R1: After reset the control/status word, both capture registers and both interrupt requests are 0.
- R2: Each channel's 2-bit edge mode selects what counts as an event: 00 no event (capture off), 01 a low-to-high transition, 10 a high-to-low transition, 11 either transition; transitions not selected change neither the flag nor the capture register.
- R3: A pin transition that is driven just after clock edge P0 and matches the mode sets the channel flag at clock edge P3 (two synchronizer stages plus one edge-detect stage).
- R4: At the edge where an event sets the flag, the capture register of that channel is loaded with the timer input value present just before that edge; it keeps its value otherwise.
- R5: The control/status word lives at address 0 with bit 7 = flag of channel 1, bit 6 = flag of channel 0, bit 5 = enable of channel 1, bit 4 = enable of channel 0, bits 3:2 = mode of channel 1, bits 1:0 = mode of channel 0; writing 0 to a flag bit clears it and writing 1 leaves it unchanged.
- R6: A read of address 0 with the read-modify-write input high returns bits 7 and 6 as 1 whatever the flags hold, and has no side effect on them.
- R7: Interrupt request i (irq bit i) is high exactly when channel i's flag and enable are both 1.
- R8: The enable and mode bits read back the value last written.
- R9: When an event and a software clear of the same flag fall on the same clock edge, the flag ends up set and the capture register is loaded.
- R10: Capture register of channel i is read at address 1+i (channel 0 at 1, channel 1 at 2), zero-extended to the read-data width; writes to these addresses change nothing, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 2 | Asynchronous event inputs, bit i for channel i |
| tmr_val | input | TW (16) | Free-running timer value to be captured |
| bus_addr | input | AW (2) | Register address |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, read data valid in the same cycle |
| bus_rmw | input | 1 | Marks the read as part of a read-modify-write access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | TW (16) | Read data, 0 when no read strobe |
| irq | output | 2 | Interrupt requests, bit i for channel i |

## Verification
The hardest situation to reach from the ports is a software clear that lands on exactly the clock edge where a synchronized pin event sets the same flag. The bench counts three edges from the moment it moves the pin and places the write strobe so that it is sampled on that third edge, then reads the word back to see which side won. The same edge counting, together with a timer value that changes right before and right after the expected edge, pins down the capture moment to a single cycle.

// File: rtl/cap_pkg.sv
package cap_pkg;

    // Number of capture channels served by one control/status word.
    localparam int NCH = 2;

    // Per-channel edge mode codes.
    localparam logic [1:0] MODE_OFF  = 2'b00;
    localparam logic [1:0] MODE_RISE = 2'b01;
    localparam logic [1:0] MODE_FALL = 2'b10;
    localparam logic [1:0] MODE_ANY  = 2'b11;

    // Control/status word, MSB first: flags, enables, modes (channel 1 above channel 0).
    typedef struct packed {
        logic [NCH-1:0]      flag;
        logic [NCH-1:0]      ien;
        logic [NCH-1:0][1:0] mode;
    } csr_t;

    localparam int CSR_W = $bits(csr_t);

endpackage

// File: rtl/cap_pin_sync.sv
module cap_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rise =  s_q.chain[STAGES-1] & ~s_q.prev;
    assign fall = ~s_q.chain[STAGES-1] &  s_q.prev;

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin,
    input  logic [1:0]    mode,
    input  logic [TW-1:0] tmr_val,
    output logic          hit,
    output logic [TW-1:0] cap_val
);

    logic rise, fall;

    cap_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin),
        .rise (rise),
        .fall (fall)
    );

    logic [TW-1:0] cap_d, cap_q;

    always_comb begin
        unique case (mode)
            MODE_RISE: hit = rise;
            MODE_FALL: hit = fall;
            MODE_ANY:  hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        cap_d = hit ? tmr_val : cap_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_val = cap_q;

endmodule

// File: rtl/cap_unit_top.sv
module cap_unit_top
    import cap_pkg::*;
#(
    parameter int TW          = 16,
    parameter int AW          = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cap_pin,
    input  logic [TW-1:0]    tmr_val,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_rmw,
    input  logic [CSR_W-1:0] bus_wdata,
    output logic [TW-1:0]    bus_rdata,
    output logic [NCH-1:0]   irq
);

    localparam logic [AW-1:0] CSR_ADDR = '0;
    localparam int            CAP_BASE = 1;

    logic [NCH-1:0]         hit;
    logic [NCH-1:0][TW-1:0] cap_val;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cap_channel #(.TW(TW), .SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (cap_pin[g]),
            .mode   (csr_q.mode[g]),
            .tmr_val(tmr_val),
            .hit    (hit[g]),
            .cap_val(cap_val[g])
        );
    end

    csr_t csr_d, csr_q;
    csr_t wr_word;
    logic csr_wr;

    assign wr_word = csr_t'(bus_wdata);
    assign csr_wr  = bus_wr && (bus_addr == CSR_ADDR);

    // Next state: software write first, hardware event set applied last so it wins.
    always_comb begin
        csr_d = csr_q;
        if (csr_wr) begin
            csr_d.ien  = wr_word.ien;
            csr_d.mode = wr_word.mode;
            csr_d.flag = csr_q.flag & wr_word.flag;
        end
        csr_d.flag = csr_d.flag | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= '0;
        else        csr_q <= csr_d;
    end

    assign irq = csr_q.flag & csr_q.ien;

    // Read path: flags forced high for read-modify-write reads.
    csr_t rd_word;

    always_comb begin
        rd_word = csr_q;
        if (bus_rmw) rd_word.flag = '1;
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == CSR_ADDR) bus_rdata = TW'(rd_word);
            for (int i = 0; i < NCH; i++) begin
                if (bus_addr == AW'(CAP_BASE + i)) bus_rdata = cap_val[i];
            end
        end
    end

endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk
    import cap_pkg::*;
#(
    parameter int TW = 16,
    parameter int AW = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [TW-1:0]          tmr_val,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_rd,
    input logic                   bus_rmw,
    input logic [TW-1:0]          bus_rdata,
    input logic [NCH-1:0]         irq,
    input logic [NCH-1:0]         flag,
    input logic [NCH-1:0][1:0]    mode,
    input logic [NCH-1:0]         hit,
    input logic [NCH-1:0][TW-1:0] cap_val
);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag == '0 && irq == '0));

    // R6
    rmw_flags_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_rmw && bus_addr == '0) |-> (bus_rdata[7:6] == 2'b11));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R4
        cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> (cap_val[g] == $past(tmr_val)));

        // R4
        cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(hit[g]) |-> $stable(cap_val[g]));

        // R2
        mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[g]) |-> ($past(mode[g]) != 2'b00));

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[g] |=> flag[g]);

        // R7
        irq_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && !bus_rmw && bus_addr == '0)
                |-> (irq[g] == (bus_rdata[6+g] & bus_rdata[4+g])));
    end

endmodule

bind cap_unit_top cap_unit_chk #(.TW(TW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmr_val  (tmr_val),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_rmw  (bus_rmw),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .flag     (csr_q.flag),
    .mode     (csr_q.mode),
    .hit      (hit),
    .cap_val  (cap_val)
);

// File: tb/tb_cap_unit_top.sv
module tb_cap_unit_top;

    localparam int TW = 16;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cap_pin = '0;
    logic [TW-1:0] tmr_val = '0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_rmw = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [TW-1:0] bus_rdata;
    logic [1:0]    irq;

    always #4 clk = ~clk;

    cap_unit_top #(.TW(TW), .AW(AW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_pin  (cap_pin),
        .tmr_val  (tmr_val),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_rmw  (bus_rmw),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [TW-1:0] exp;
        string         tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected item for every read cycle.
    always @(negedge clk) begin
        if (bus_rd && !done) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "scoreboard underflow", 0, 0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                chk(bus_rdata === it.exp, it.tag, int'(bus_rdata), int'(it.exp));
            end
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic rmw,
                            input logic [TW-1:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rmw = rmw; bus_rd = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        @(posedge clk); #1;
        bus_rd = 1'b0; bus_rmw = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_irq(input logic [1:0] exp, input string tag);
        @(negedge clk);
        chk(irq === exp, tag, int'(irq), int'(exp));
    endtask

    // Pin moves after edge P0; flag/irq must appear exactly at P3 with the value seen just before P3.
    task automatic timed_edge(input int ch, input logic lvl, input logic [TW-1:0] tv,
                              input string tag);
        @(posedge clk); #1;
        cap_pin[ch] = lvl; tmr_val = ~tv;
        @(posedge clk);
        @(posedge clk); #1;
        tmr_val = tv;
        @(negedge clk);
        chk(irq[ch] === 1'b0, {tag, " irq before P3"}, int'(irq[ch]), 0);
        @(posedge clk); #1;
        tmr_val = tv + 16'd1;
        @(negedge clk);
        chk(irq[ch] === 1'b1, {tag, " irq at P3"}, int'(irq[ch]), 1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check_irq(2'b00, "R1 irq after reset");
        bus_read(2'd0, 1'b0, 16'h0000, "R1 csr after reset");
        bus_read(2'd1, 1'b0, 16'h0000, "R1 cap0 after reset");
        bus_read(2'd2, 1'b0, 16'h0000, "R1 cap1 after reset");

        // R8 read/write bits; R5 writing 1 to flags does not set them
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, 1'b0, 16'h003F, "R8 R5 csr after all-ones write");
        bus_write(2'd0, 8'h00);
        bus_read(2'd0, 1'b0, 16'h0000, "R8 csr after zero write");

        // R2 mode 00: no events
        bus_write(2'd0, 8'h30);
        @(posedge clk); #1; cap_pin[0] = 1'b1;
        idle(4);
        cap_pin[0] = 1'b0;
        idle(4);
        bus_read(2'd0, 1'b0, 16'h0030, "R2 off mode ignores pin");
        bus_read(2'd1, 1'b0, 16'h0000, "R2 off mode no capture");
        check_irq(2'b00, "R2 off mode irq");

        // R3 R4 rising on channel 0
        bus_write(2'd0, 8'h31);
        timed_edge(0, 1'b1, 16'h1234, "R3 rise ch0");
        bus_read(2'd1, 1'b0, 16'h1234, "R4 cap0 value");
        bus_read(2'd0, 1'b0, 16'h0071, "R3 csr flag0 set");

        // R2 falling transition ignored in rise mode
        @(posedge clk); #1; cap_pin[0] = 1'b0; tmr_val = 16'h9999;
        idle(5);
        bus_read(2'd1, 1'b0, 16'h1234, "R2 rise mode ignores fall");

        // R6 read-modify-write view
        bus_read(2'd0, 1'b1, 16'h00F1, "R6 rmw read");
        bus_read(2'd0, 1'b0, 16'h0071, "R6 rmw read no side effect");

        // R5 clear by writing 0
        bus_write(2'd0, 8'h31);
        bus_read(2'd0, 1'b0, 16'h0031, "R5 flag0 cleared");
        check_irq(2'b00, "R5 irq after clear");

        // R2 falling mode on channel 1
        bus_write(2'd0, 8'h38);
        @(posedge clk); #1; cap_pin[1] = 1'b1;
        idle(5);
        bus_read(2'd0, 1'b0, 16'h0038, "R2 fall mode ignores rise");
        timed_edge(1, 1'b0, 16'hBEEF, "R2 fall ch1");
        bus_read(2'd2, 1'b0, 16'hBEEF, "R4 cap1 value");
        bus_read(2'd0, 1'b0, 16'h00B8, "R3 csr flag1 set");

        // R2 both-edge mode on channel 0
        bus_write(2'd0, 8'hBB);
        timed_edge(0, 1'b1, 16'h0A0A, "R2 any-mode rise ch0");
        bus_read(2'd1, 1'b0, 16'h0A0A, "R4 cap0 any-mode rise");
        bus_write(2'd0, 8'hFB);
        bus_read(2'd0, 1'b0, 16'h00FB, "R5 writing 1 keeps flags");
        bus_write(2'd0, 8'hBB);
        bus_read(2'd0, 1'b0, 16'h00BB, "R5 flag0 cleared again");
        timed_edge(0, 1'b0, 16'h5050, "R2 any-mode fall ch0");
        bus_read(2'd1, 1'b0, 16'h5050, "R4 cap0 any-mode fall");
        bus_read(2'd0, 1'b0, 16'h00FB, "R2 csr after any-mode fall");

        // R7 interrupt gating by enables
        bus_write(2'd0, 8'hCB);
        check_irq(2'b00, "R7 enables off");
        bus_read(2'd0, 1'b0, 16'h00CB, "R7 csr enables off");
        bus_write(2'd0, 8'hEB);
        check_irq(2'b10, "R7 only ch1 enabled");
        bus_write(2'd0, 8'hDB);
        check_irq(2'b01, "R7 only ch0 enabled");

        // R9 event and clear on the same edge
        bus_write(2'd0, 8'h9B);
        bus_read(2'd0, 1'b0, 16'h009B, "R9 flag0 clear before race");
        @(posedge clk); #1;
        cap_pin[0] = 1'b1; tmr_val = 16'h7777;
        @(posedge clk);
        @(posedge clk); #1;
        bus_addr = 2'd0; bus_wdata = 8'h9B; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        bus_read(2'd0, 1'b0, 16'h00DB, "R9 set wins over clear");
        bus_read(2'd1, 1'b0, 16'h7777, "R9 capture on race edge");

        // R10 capture registers read-only, unmapped address reads 0
        bus_write(2'd1, 8'h55);
        bus_write(2'd2, 8'hAA);
        bus_read(2'd1, 1'b0, 16'h7777, "R10 cap0 ignores write");
        bus_read(2'd2, 1'b0, 16'hBEEF, "R10 cap1 ignores write");
        bus_read(2'd3, 1'b0, 16'h0000, "R10 unmapped address");
        bus_read(2'd0, 1'b0, 16'h00DB, "R10 csr untouched by cap writes");

        idle(2);
        chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule